// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Byte Error Tags

This block turns an asynchronous serial stream into bytes. It advances only on a one-clock enable that pulses sixteen times per bit period. When the idle-high line falls, it waits half a bit and checks the line again, which filters out glitches. It then samples each data bit, the optional parity bit and the first stop bit at the centre of its bit period. A finished character goes into a one-byte holding register. Three tags are stored next to the byte and describe that byte alone: parity error, framing error and break.

The host reads the byte and then pulses `rd_data`, which frees the holding register. An overrun flag records that a character arrived while the previous one was still unread. In that case the new character is thrown away and the held byte is kept. A read of line status, marked by `rd_status`, clears the overrun flag. A loopback select replaces the external line with an internal stream, so the receiver can be tested without the pin.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `data_ready`, `overrun`, `parity_err`, `frame_err`, `break_det` and `rx_byte` are all 0.
- R2: A falling edge of the line starts a half-bit wait of 8 ticks. If the line is high again when that wait ends, the event is dropped and no byte is loaded.
- R3: Data bits are sampled every 16 ticks after the start sample, least significant bit first. `word_len` selects 5, 6, 7 or 8 bits for 00, 01, 10 or 11. Unused upper bits of `rx_byte` read 0.
- R4: The receiver checks a parity bit only when `par_en`=1. With `par_force`=0, `par_even`=1 selects even parity and `par_even`=0 selects odd parity. With `par_force`=1, the expected parity bit is 1 when `par_even`=0 and 0 when `par_even`=1. A mismatch sets `parity_err` for that byte.
- R5: A 0 sampled at the first stop bit sets `frame_err` for that byte.
- R6: If every sampled bit of a frame is 0, the receiver loads byte 0x00 with `break_det`=1, `frame_err`=1 and `parity_err`=0. It then accepts no new start until the line has been high.
- R7: `data_ready` rises when a byte is loaded. A pulse on `rd_data` clears `data_ready` and the three tags.
- R8: When a character completes while `data_ready`=1, `overrun` sets, the new character is discarded, and `rx_byte` and its tags are unchanged. A pulse on `rd_status` clears `overrun`.
- R9: With `loop_en`=1, the receiver takes its input from `loop_in` and ignores `rx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Enable, pulses 16 times per bit |
| rx_in | input | 1 | External serial line, idle high |
| loop_en | input | 1 | Selects `loop_in` as the input |
| loop_in | input | 1 | Internal loopback stream |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity, or space when forced |
| par_force | input | 1 | Forced parity value |
| rd_data | input | 1 | Host read of the data byte |
| rd_status | input | 1 | Host read of line status |
| rx_byte | output | 8 | Held byte |
| data_ready | output | 1 | Unread byte held |
| overrun | output | 1 | Character lost while a byte was held |
| parity_err | output | 1 | Parity tag of the held byte |
| frame_err | output | 1 | Framing tag of the held byte |
| break_det | output | 1 | Break tag of the held byte |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver that skipped the mid-start check would build a phantom byte from it. The bench then sends a second character without reading the first. A design that overwrote the held byte, or that let the new character's tags replace the held ones, returns the wrong data. A break held for longer than one frame checks that exactly one zero byte appears and that the line must go high before the next start is accepted. A design that re-armed on the still-low line would produce a stream of zero bytes. Forced mark and forced space parity checks catch a swapped meaning of `par_even`. The loopback run holds `rx_in` low, which would otherwise look like a break.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OVS   = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       loop_en,
  input  logic       loop_in,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_force,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_byte,
  output logic       data_ready,
  output logic       overrun,
  output logic       parity_err,
  output logic       frame_err,
  output logic       break_det
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t st;
  logic [SYNC-1:0] sync;
  logic [CW-1:0]   cnt;
  logic [2:0]      bitn;
  logic [7:0]      shreg;
  logic            par_bit, all_zero, rx_last;

  wire line_in  = loop_en ? loop_in : rx_in;
  wire rx_s     = sync[SYNC-1];
  wire [2:0] last_bit = {1'b0, word_len} + 3'd4;
  wire exp_par  = par_force ? ~par_even : (par_even ? ^shreg : ~^shreg);
  wire is_brk   = all_zero & ~rx_s;
  wire at_end   = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC-2:0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      par_bit <= 1'b0; all_zero <= 1'b0; rx_last <= 1'b1;
      rx_byte <= '0; data_ready <= 1'b0; overrun <= 1'b0;
      parity_err <= 1'b0; frame_err <= 1'b0; break_det <= 1'b0;
    end else begin
      if (rd_data) begin
        data_ready <= 1'b0; parity_err <= 1'b0;
        frame_err <= 1'b0;  break_det <= 1'b0;
      end
      if (rd_status) overrun <= 1'b0;
      if (tick) begin
        rx_last <= rx_s;
        case (st)
          S_IDLE: if (rx_last && !rx_s) begin
            st <= S_START; cnt <= '0;
          end
          S_START: if (cnt == MID) begin
            cnt <= '0;
            if (rx_s) st <= S_IDLE;
            else begin
              st <= S_DATA; bitn <= '0; shreg <= '0; all_zero <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
          S_DATA: if (at_end) begin
            cnt <= '0;
            shreg[bitn] <= rx_s;
            all_zero <= all_zero & ~rx_s;
            if (bitn == last_bit) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (at_end) begin
            cnt <= '0; par_bit <= rx_s;
            all_zero <= all_zero & ~rx_s;
            st <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (at_end) begin
            cnt <= '0;
            st <= is_brk ? S_HOLD : S_IDLE;
            if (data_ready && !rd_data) overrun <= 1'b1;
            else begin
              data_ready <= 1'b1;
              rx_byte    <= is_brk ? 8'h00 : shreg;
              parity_err <= par_en & ~is_brk & (par_bit != exp_par);
              frame_err  <= ~rx_s;
              break_det  <= is_brk;
            end
          end else cnt <= cnt + 1'b1;
          S_HOLD: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_data,
  input logic       rd_status,
  input logic [7:0] rx_byte,
  input logic       data_ready,
  input logic       overrun,
  input logic       frame_err,
  input logic       break_det
);
  a_r7_ready_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(rd_data));
  a_r8_held_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready && $past(data_ready) && !$past(rd_data) |-> $stable(rx_byte));
  a_r6_break_tags: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> frame_err && rx_byte == 8'h00);
  a_r8_overrun_needs_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> data_ready && $past(data_ready));
  a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(rd_status));
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_status(rd_status),
  .rx_byte(rx_byte), .data_ready(data_ready), .overrun(overrun),
  .frame_err(frame_err), .break_det(break_det)
);

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
  logic clk = 0, rst_n = 0;
  logic rx_in = 1, loop_en = 0, loop_in = 1;
  logic [1:0] word_len = 2'b11;
  logic par_en = 0, par_even = 0, par_force = 0;
  logic rd_data = 0, rd_status = 0;
  logic [7:0] rx_byte;
  logic data_ready, overrun, parity_err, frame_err, break_det;
  logic [1:0] tdiv = 0;
  logic tick;
  int total = 0, bad = 0;
  bit use_loop = 0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
  assign tick = (tdiv == 2'd0);

  uart_rx_core uut (.*);

  // {word_len, par_en, par_even, par_force, data, corrupt parity, bad stop}
  localparam logic [14:0] VEC [9] = '{
    {2'b11, 3'b000, 8'hA5, 2'b00},
    {2'b00, 3'b000, 8'hFF, 2'b00},
    {2'b01, 3'b000, 8'h3C, 2'b00},
    {2'b10, 3'b000, 8'h55, 2'b00},
    {2'b11, 3'b110, 8'h81, 2'b00},
    {2'b11, 3'b100, 8'h81, 2'b10},
    {2'b11, 3'b101, 8'h6E, 2'b00},
    {2'b11, 3'b111, 8'h6E, 2'b10},
    {2'b11, 3'b000, 8'h3C, 2'b01}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  task automatic drive(input logic v, input int nt);
    if (use_loop) loop_in = v; else rx_in = v;
    wait_ticks(nt);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen,
                      input logic pbit, input logic stopv);
    drive(1'b0, 16);
    for (int i = 0; i < nb; i++) drive(d[i], 16);
    if (pen) drive(pbit, 16);
    drive(stopv, 16);
    drive(1'b1, 16);
  endtask

  task automatic pulse_rd(input bit st);
    @(negedge clk);
    if (st) rd_status = 1; else rd_data = 1;
    @(negedge clk);
    rd_status = 0; rd_data = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", data_ready, 0);
    chk("R1 flags", {overrun, parity_err, frame_err, break_det}, 0);
    chk("R1 byte", rx_byte, 0);
    rst_n = 1;
    wait_ticks(4);

    for (int v = 0; v < 9; v++) begin
      logic [7:0] d, m, md;
      logic pbit;
      int nb;
      word_len = VEC[v][14:13]; par_en = VEC[v][12];
      par_even = VEC[v][11]; par_force = VEC[v][10];
      d = VEC[v][9:2];
      nb = 5 + int'(word_len);
      m = 8'((16'd1 << nb) - 1);
      md = d & m;
      pbit = par_force ? ~par_even : (par_even ? ^md : ~^md);
      pbit ^= VEC[v][1];
      send(d, nb, par_en, pbit, ~VEC[v][0]);
      chk("R3 byte/word length", rx_byte, md);
      chk("R7 ready set", data_ready, 1);
      chk("R4 parity tag", parity_err, par_en & VEC[v][1]);
      chk("R5 framing tag", frame_err, VEC[v][0]);
      pulse_rd(0);
      chk("R7 ready cleared", data_ready, 0);
      chk("R7 tags cleared", {parity_err, frame_err, break_det}, 0);
    end

    word_len = 2'b11; par_en = 0; par_even = 0; par_force = 0;
    drive(1'b0, 4); drive(1'b1, 40);
    chk("R2 false start ignored", data_ready, 0);

    drive(1'b0, 16 * 20);
    chk("R6 break byte", rx_byte, 8'h00);
    chk("R6 break tags", {break_det, frame_err, parity_err}, 3'b110);
    pulse_rd(0);
    drive(1'b0, 16 * 12);
    chk("R6 no rearm while low", data_ready, 0);
    drive(1'b1, 8);
    send(8'h5A, 8, 0, 0, 1);
    chk("R6 recovered after high", rx_byte, 8'h5A);
    pulse_rd(0);

    send(8'h11, 8, 0, 0, 1);
    send(8'h22, 8, 0, 0, 0);
    chk("R8 overrun set", overrun, 1);
    chk("R8 held byte kept", rx_byte, 8'h11);
    chk("R8 held tags kept", frame_err, 0);
    pulse_rd(1);
    chk("R8 overrun cleared", overrun, 0);
    chk("R8 byte still ready", data_ready, 1);
    pulse_rd(0);

    loop_en = 1; rx_in = 0; use_loop = 1;
    drive(1'b1, 8);
    send(8'hC3, 8, 0, 0, 1);
    chk("R9 loopback byte", rx_byte, 8'hC3);
    chk("R9 rx_in ignored", break_det, 0);
    pulse_rd(0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule